// File: doc/BRIEF.md
# Debounced Two-Line Keypad Sense with Interrupt

This block collects the state of sixteen keys from two return lines while a display multiplexer steps through its eight segment positions. Each return line is sampled once per segment position, and the samples form one eight-bit word per line for every full pass. A word is accepted into the reported key register only after it has stayed unchanged for a set number of millisecond ticks. Any accepted change pulls the interrupt line low. The line is released when the host starts reading the key registers.

Two positions on the first return line can be used as address straps instead of keys. When strapping is enabled, those two sampled bits go straight to the bus-address logic with no filtering. They read as open in the key register and never start a settle window or an interrupt. While the display is blinking the key samples are not trusted, so the settle counter is frozen and the reported value is held.

Top module: `keypad_sense`

## Requirements
- R1: After reset both key registers read 0xFF, the interrupt is released (`irq_pull_o` = 0) and the strap output reads 2'b11.
- R2: A strobe with `slot_sel` = s stores the return level into bit s of that line's word (bit 7 = decimal point, bits 6..0 = segments A..G, bit 0 = G). A pressed key reads 0 and an open key reads 1. A pass closes on the strobe with `slot_sel` = 0.
- R3: A new word reaches a key register only after DEB_MS millisecond ticks with no differing pass. After DEB_MS-1 ticks the register is unchanged.
- R4: Each accepted change sets `irq_pull_o` to 1, and it stays 1 across further ticks until a read starts.
- R5: A pulse on `key_rd_start` releases the interrupt on the next clock, unless a change is accepted in that same cycle.
- R6: A pass whose word differs from the pending candidate restarts the settle count from zero.
- R7: While `blink_en` is 1 the key registers hold and ticks do not advance the settle count.
- R8: Passes that repeat the already reported word never raise the interrupt.
- R9: With `strap_en` = 1, `strap_o` = {bit 1 (F), bit 0 (G)} of the latest first-line pass, with no settle delay. With `strap_en` = 0 it holds its value.
- R10: With `strap_en` = 1, bits 1:0 of `key_a_o` read 1, and changes on those two positions neither raise the interrupt nor touch the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_stb | input | 1 | One-cycle strobe: the return lines are valid for the selected segment position |
| slot_sel | input | 3 | Segment position being driven (bit index in the key word) |
| ret_a | input | 1 | First key return line (0 = pressed) |
| ret_b | input | 1 | Second key return line (0 = pressed) |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| blink_en | input | 1 | Display blinking; key samples invalid |
| strap_en | input | 1 | Use first-line positions F and G as address straps |
| key_rd_start | input | 1 | Pulse when a read of the key registers begins |
| key_a_o | output | 8 | Debounced first-line key register |
| key_b_o | output | 8 | Debounced second-line key register |
| strap_o | output | 2 | Undebounced address strap bits {A1, A0} |
| irq_pull_o | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
A single press on one segment tells a correct bit mapping apart from a reversed or shifted one. A press at each end of the second line (DP and G together) checks both edges of the word. A window held for DEB_MS-1 and then DEB_MS ticks separates a correct settle length from an off-by-one. A press that changes partway through the window shows whether a mismatch restarts the count. A blink interval longer than the window shows that ticks are frozen, because a full window is still needed afterwards. Two strap patterns (both shorted, then only G shorted) give distinct `strap_o` values and separate F from G. Presses on the strapped positions, and then a strapped read-out of a register holding zeros there, show that those positions are removed from the key path.

// File: rtl/keypad_sense_pkg.sv
// Shared constants for the keypad sense block.
// Assumes an eight-position segment scan per return line.
package keypad_sense_pkg;
    localparam int KEY_LINES  = 2;
    localparam int SEG_COUNT  = 8;
    localparam int SEL_W      = $clog2(SEG_COUNT);
    localparam int STRAP_BITS = 2;
    typedef logic [SEG_COUNT-1:0] key_word_t;
endpackage

// File: rtl/key_frame_capture.sv
// Builds one key word per scan pass from a single return line.
// Assumes slot strobes arrive one position at a time and that the pass
// ends with the position-0 strobe. The completed word is output with a
// one-cycle valid pulse.
module key_frame_capture #(
    parameter int W     = 8,
    parameter int SEL_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_stb,
    input  logic [SEL_W-1:0] slot_sel,
    input  logic             ret_in,
    output logic             frame_vld_o,
    output logic [W-1:0]     frame_o
);
    logic [W-1:0] work_q;
    logic [W-1:0] work_next;
    logic [W-1:0] frame_q;
    logic         vld_q;

    // Place the current return level into the selected bit position.
    always_comb begin
        work_next           = work_q;
        work_next[slot_sel] = ret_in;
    end

    // Accumulate samples and publish the word when the pass closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q  <= '1;
            frame_q <= '1;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (slot_stb) begin
                work_q <= work_next;
                if (slot_sel == '0) begin
                    frame_q <= work_next;
                    vld_q   <= 1'b1;
                end
            end
        end
    end

    assign frame_vld_o = vld_q;
    assign frame_o     = frame_q;

    // R2: a completed pass only follows a position-0 strobe
    assert_pass_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld_o |-> $past(slot_stb && (slot_sel == '0)));
endmodule

// File: rtl/key_settle_filter.sv
// Holds a candidate word and promotes it to the reported register once it
// has survived DEB_MS millisecond ticks without a differing pass.
// Assumes frame_in is valid only with frame_vld. The hold input freezes
// both counting and promotion.
module key_settle_filter #(
    parameter int W      = 8,
    parameter int DEB_MS = 20,
    parameter int CNT_W  = $clog2(DEB_MS + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_vld,
    input  logic [W-1:0] frame_in,
    input  logic         tick,
    input  logic         hold,
    output logic [W-1:0] stored_o,
    output logic         commit_o
);
    localparam logic [CNT_W-1:0] DEB_C = CNT_W'(DEB_MS);

    logic [W-1:0]     cand_q;
    logic [W-1:0]     stored_q;
    logic [CNT_W-1:0] cnt_q;
    logic             mismatch;
    logic             commit;

    // Detect a pass that differs from the pending candidate.
    always_comb mismatch = frame_vld && (frame_in != cand_q);

    // Promote the candidate when its window is complete and it is new.
    always_comb commit = !hold && (cnt_q == DEB_C) && (cand_q != stored_q);

    // Track the candidate and its settle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= '1;
            cnt_q  <= '0;
        end else if (mismatch) begin
            cand_q <= frame_in;
            cnt_q  <= '0;
        end else if (tick && !hold && (cnt_q < DEB_C)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Update the reported register on promotion.
    always_ff @(posedge clk) begin
        if (!rst_n) stored_q <= '1;
        else if (commit) stored_q <= cand_q;
    end

    assign stored_o = stored_q;
    assign commit_o = commit;

    // R3: the reported value only moves after a full window
    assert_settle_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stored_q) |-> $past(cnt_q == DEB_C));
    // R3: the settle count never runs past the window
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DEB_C);
    // R7: blinking freezes the reported value
    assert_blink_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(stored_q));
    // R6: a differing pass restarts the count
    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> (cnt_q == '0));
endmodule

// File: rtl/keypad_sense.sv
// Top of the keypad sense block: two capture/filter lanes, the address
// strap path and the interrupt flag.
// Assumes ms_tick and key_rd_start are single-cycle pulses in the clk domain.
module keypad_sense
    import keypad_sense_pkg::*;
#(
    parameter int DEB_MS = 20,
    parameter int SEGS   = SEG_COUNT,
    parameter int SW     = $clog2(SEGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slot_stb,
    input  logic [SW-1:0]   slot_sel,
    input  logic            ret_a,
    input  logic            ret_b,
    input  logic            ms_tick,
    input  logic            blink_en,
    input  logic            strap_en,
    input  logic            key_rd_start,
    output logic [SEGS-1:0] key_a_o,
    output logic [SEGS-1:0] key_b_o,
    output logic [1:0]      strap_o,
    output logic            irq_pull_o
);
    localparam int LANES = KEY_LINES;

    logic [LANES-1:0]           ret_vec;
    logic [LANES-1:0]           frm_vld;
    logic [LANES-1:0][SEGS-1:0] frm_word;
    logic [LANES-1:0][SEGS-1:0] filt_in;
    logic [LANES-1:0][SEGS-1:0] stored;
    logic [LANES-1:0]           commit;
    logic [SEGS-1:0]            strap_mask;
    logic [1:0]                 strap_q;
    logic                       irq_q;
    logic                       commit_any;

    assign ret_vec = {ret_b, ret_a};

    // Positions used as straps are forced open on the key path.
    always_comb begin
        strap_mask = '0;
        if (strap_en) strap_mask[STRAP_BITS-1:0] = '1;
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            key_frame_capture #(.W(SEGS), .SEL_W(SW)) u_cap (
                .clk         (clk),
                .rst_n       (rst_n),
                .slot_stb    (slot_stb),
                .slot_sel    (slot_sel),
                .ret_in      (ret_vec[g]),
                .frame_vld_o (frm_vld[g]),
                .frame_o     (frm_word[g])
            );
            if (g == 0) begin : g_strapped
                assign filt_in[g] = frm_word[g] | strap_mask;
            end else begin : g_plain
                assign filt_in[g] = frm_word[g];
            end
            key_settle_filter #(.W(SEGS), .DEB_MS(DEB_MS)) u_filt (
                .clk       (clk),
                .rst_n     (rst_n),
                .frame_vld (frm_vld[g]),
                .frame_in  (filt_in[g]),
                .tick      (ms_tick),
                .hold      (blink_en),
                .stored_o  (stored[g]),
                .commit_o  (commit[g])
            );
        end
    endgenerate

    assign commit_any = |commit;

    // Capture strap levels straight from each first-line pass.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= '1;
        else if (strap_en && frm_vld[0]) strap_q <= frm_word[0][1:0];
    end

    // Interrupt flag: set by an accepted change, cleared by a read start.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else if (commit_any) irq_q <= 1'b1;
        else if (key_rd_start) irq_q <= 1'b0;
    end

    assign key_a_o    = stored[0] | strap_mask;
    assign key_b_o    = stored[1];
    assign strap_o    = strap_q;
    assign irq_pull_o = irq_q;

    // R4: the interrupt only asserts after an accepted change
    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(commit_any));
    // R5: a read start without a new change releases the line
    assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_rd_start && !commit_any) |=> !irq_q);
    // R9: strap bits only move on a first-line pass with strapping on
    assert_strap_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(strap_q) |-> $past(strap_en && frm_vld[0]));
endmodule

// File: tb/keypad_sense_tb.sv
module keypad_sense_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_stb = 1'b0;
    logic [2:0] slot_sel = 3'd0;
    logic       ret_a = 1'b1, ret_b = 1'b1;
    logic       ms_tick = 1'b0, blink_en = 1'b0, strap_en = 1'b0, key_rd_start = 1'b0;
    logic [7:0] key_a_o, key_b_o;
    logic [1:0] strap_o;
    logic       irq_pull_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    logic [15:0] last_obs = 16'hFFFF;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    keypad_sense #(.DEB_MS(20)) u_dut (
        .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .slot_sel(slot_sel),
        .ret_a(ret_a), .ret_b(ret_b), .ms_tick(ms_tick), .blink_en(blink_en),
        .strap_en(strap_en), .key_rd_start(key_rd_start),
        .key_a_o(key_a_o), .key_b_o(key_b_o), .strap_o(strap_o), .irq_pull_o(irq_pull_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic slot(input int s, input logic a, input logic b);
        @(negedge clk);
        slot_stb = 1'b1; slot_sel = 3'(s); ret_a = a; ret_b = b;
        @(negedge clk);
        slot_stb = 1'b0;
    endtask

    task automatic send_pass(input logic [7:0] wa, input logic [7:0] wb);
        for (int s = 7; s >= 0; s--) slot(s, wa[s], wb[s]);
        repeat (2) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic read_keys();
        @(negedge clk); key_rd_start = 1'b1;
        @(negedge clk); key_rd_start = 1'b0;
    endtask

    // Driver side of the scoreboard: record an expected register update.
    task automatic expect_update(input logic [7:0] a, input logic [7:0] b);
        exp_q.push_back({a, b});
    endtask

    // Monitor: every change at the key outputs must match the next expected item.
    always @(negedge clk) begin
        if (mon_on && ({key_a_o, key_b_o} !== last_obs)) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected update", {key_a_o, key_b_o}, last_obs);
            end else begin
                check("R3 update value", {key_a_o, key_b_o}, exp_q.pop_front());
                check("R4 irq on update", {15'd0, irq_pull_o}, 16'd1);
            end
            last_obs = {key_a_o, key_b_o};
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 key_a reset", {8'd0, key_a_o}, 16'h00FF);
        check("R1 key_b reset", {8'd0, key_b_o}, 16'h00FF);
        check("R1 irq reset", {15'd0, irq_pull_o}, 16'd0);
        check("R1 strap reset", {14'd0, strap_o}, 16'd3);
        mon_on = 1'b1;

        // R2/R3: press segment A on line A; window edge
        send_pass(8'hBF, 8'hFF);
        ticks(19);
        check("R3 before window", {key_a_o, key_b_o}, 16'hFFFF);
        check("R3 no irq before window", {15'd0, irq_pull_o}, 16'd0);
        expect_update(8'hBF, 8'hFF);
        ticks(1);
        check("R2 segment A bit6", {8'd0, key_a_o}, 16'h00BF);
        ticks(5);
        check("R4 irq held", {15'd0, irq_pull_o}, 16'd1);
        read_keys();
        @(negedge clk);
        check("R5 irq released", {15'd0, irq_pull_o}, 16'd0);

        // R2: both ends of line B (DP and G)
        send_pass(8'hBF, 8'h7E);
        expect_update(8'hBF, 8'h7E);
        ticks(20);
        check("R2 DP and G on line B", {8'd0, key_b_o}, 16'h007E);
        read_keys();

        // R6: change mid-window restarts the count
        send_pass(8'hBF, 8'hFF);
        ticks(10);
        send_pass(8'hBF, 8'hF7);
        ticks(19);
        check("R6 restart holds value", {8'd0, key_b_o}, 16'h007E);
        expect_update(8'hBF, 8'hF7);
        ticks(1);
        read_keys();

        // R7: blinking freezes counting and value
        send_pass(8'hFF, 8'hF7);
        blink_en = 1'b1;
        ticks(30);
        check("R7 held in blink", {8'd0, key_a_o}, 16'h00BF);
        check("R7 no irq in blink", {15'd0, irq_pull_o}, 16'd0);
        blink_en = 1'b0;
        ticks(19);
        check("R7 counter frozen", {8'd0, key_a_o}, 16'h00BF);
        expect_update(8'hFF, 8'hF7);
        ticks(1);
        read_keys();
        @(negedge clk);

        // R8: repeating the reported word raises nothing
        send_pass(8'hFF, 8'hF7);
        ticks(25);
        check("R8 no irq on same word", {15'd0, irq_pull_o}, 16'd0);
        check("R8 value kept", {key_a_o, key_b_o}, 16'hFFF7);
        check("R3 scoreboard drained", 16'(exp_q.size()), 16'd0);

        // R9/R10: strap positions leave the key path
        mon_on = 1'b0;
        strap_en = 1'b1;
        send_pass(8'hFC, 8'hF7);
        check("R9 strap both shorted", {14'd0, strap_o}, 16'd0);
        ticks(25);
        check("R10 no irq from strap pins", {15'd0, irq_pull_o}, 16'd0);
        check("R10 key_a unchanged", {8'd0, key_a_o}, 16'h00FF);
        send_pass(8'hFE, 8'hF7);
        check("R9 strap G shorted F open", {14'd0, strap_o}, 16'd2);
        strap_en = 1'b0;
        send_pass(8'hFD, 8'hF7);
        check("R9 strap holds when off", {14'd0, strap_o}, 16'd2);
        send_pass(8'hFC, 8'hF7);
        ticks(20);
        check("R10 keys when strapping off", {8'd0, key_a_o}, 16'h00FC);
        read_keys();
        @(negedge clk);
        strap_en = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 strapped bits read open", {8'd0, key_a_o}, 16'h00FF);
        check("R10 no irq on strap enable", {15'd0, irq_pull_o}, 16'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule